// File: doc/BRIEF.md
# Ripple-Carry Arithmetic-Logic Unit with Overflow Detection

This block is a purely combinational arithmetic-logic unit whose operand width is a parameter (8 bits by default). It is assembled from a row of identical one-bit slices joined by a ripple carry. Each slice evaluates every function at once, and a per-slice output selector keyed by a 3-bit operation code picks the value that drives that result bit. Subtraction reuses the adder. A per-bit invert selector complements operand B and the carry into the lowest slice is forced high, so the adder forms A plus the two's complement of B.

Signed and unsigned add and subtract produce identical result bits and carry. The only difference between them is the overflow rule. The unsigned forms flag a carry out of the top slice on add, or a missing carry (a borrow) on subtract. The signed forms flag a result whose sign disagrees with two like-signed adder inputs. The overflow output is meant to drive an exception unit elsewhere in the chip. Set-on-less-than gives a signed comparison. It runs a subtract and corrects the sign of the difference with the signed overflow condition.

Top module: `ripple_alu`

## Requirements
- R1: Code 000 gives `y_o = a_i & b_i` and code 001 gives `y_o = a_i | b_i`, bit by bit.
- R2: Code 101 gives `y_o = ~a_i`, and `b_i` has no effect on any output.
- R3: For codes 000, 001 and 101, both `carry_o` and `ovf_o` are 0.
- R4: Code 010 (signed add) gives `y_o = (a_i + b_i) mod 2^WIDTH`, and `carry_o` is the carry out of the top bit of that sum.
- R5: Code 011 (signed subtract) gives `y_o = (a_i - b_i) mod 2^WIDTH`, and `carry_o` is the carry out of `a_i + ~b_i + 1`.
- R6: For codes 010 and 011, `ovf_o` is 1 exactly when the true signed sum or difference of the two's-complement operands falls outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R7: Code 110 (unsigned add) gives the same `y_o` and `carry_o` as code 010, and `ovf_o` equals `carry_o`.
- R8: Code 111 (unsigned subtract) gives the same `y_o` and `carry_o` as code 011, and `ovf_o` is 1 exactly when `a_i < b_i` as unsigned values.
- R9: Code 100 (set-on-less-than) gives `y_o[0] = 1` when `a_i < b_i` as signed values and 0 otherwise, with all other bits of `y_o` 0 and both `carry_o` and `ovf_o` 0, including when the internal difference overflows.
- R10: Every rule above holds for each WIDTH of 2 or more, with the carry rippling through one slice per bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 3 | Operation code |
| y_o | output | WIDTH | Result |
| carry_o | output | 1 | Carry out of the top slice for add and subtract codes, otherwise 0 |
| ovf_o | output | 1 | Overflow flag for the exception unit |

## Verification
The bench builds two instances. One uses the default WIDTH of 8, where directed patterns reach the signed extremes: the most negative value added to itself, the largest value minus the most negative, and all-ones plus one for the unsigned carry. The other uses a WIDTH of 4, small enough that every operand pair under every operation code can be compared with a wide-integer reference. That sweep covers every carry and borrow edge, every signed overflow case and every set-on-less-than outcome, including those where the internal difference overflows.

// File: rtl/alu_pkg.sv
// Package: shared operation codes for the ripple ALU.
// Assumes a 3-bit code; the bit pattern of each code is fixed behaviour.
package alu_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_SADD = 3'b010,
        OP_SSUB = 3'b011,
        OP_SLT  = 3'b100,
        OP_NOTA = 3'b101,
        OP_UADD = 3'b110,
        OP_USUB = 3'b111
    } alu_op_e;

endpackage

// File: rtl/alu_op_decode.sv
// Module: alu_op_decode
// Turns the operation code into datapath and flag controls. It is purely
// combinational and assumes every 3-bit value is a legal code.
module alu_op_decode
    import alu_pkg::*;
(
    input  alu_op_e op_i,
    output logic    inv_b_o,    // complement B and force carry-in high
    output logic    arith_o,    // carry out is reported
    output logic    sgn_ovf_o,  // signed overflow rule applies
    output logic    uadd_o,     // unsigned add overflow rule
    output logic    usub_o      // unsigned subtract borrow rule
);

    // Purpose: map each code onto its control set.
    always_comb begin
        inv_b_o   = 1'b0;
        arith_o   = 1'b0;
        sgn_ovf_o = 1'b0;
        uadd_o    = 1'b0;
        usub_o    = 1'b0;
        unique case (op_i)
            OP_SADD: begin
                arith_o   = 1'b1;
                sgn_ovf_o = 1'b1;
            end
            OP_SSUB: begin
                inv_b_o   = 1'b1;
                arith_o   = 1'b1;
                sgn_ovf_o = 1'b1;
            end
            OP_SLT:  inv_b_o = 1'b1;
            OP_UADD: begin
                arith_o = 1'b1;
                uadd_o  = 1'b1;
            end
            OP_USUB: begin
                inv_b_o = 1'b1;
                arith_o = 1'b1;
                usub_o  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_bit_cell.sv
// Module: alu_bit_cell
// One slice of the ALU. It computes AND, OR, NOT A and a full-adder sum in
// parallel and selects one of them by code. B passes through an invert
// selector before the adder. less_i is the set-on-less-than bit. It is only
// nonzero for slice 0.
module alu_bit_cell
    import alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    cin_i,
    input  logic    inv_i,
    input  logic    less_i,
    input  alu_op_e op_i,
    output logic    res_o,
    output logic    sum_o,
    output logic    cout_o,
    output logic    bx_o
);

    // Purpose: invert selector on B, then the full adder.
    always_comb begin
        bx_o   = inv_i ? ~b_i : b_i;
        sum_o  = a_i ^ bx_o ^ cin_i;
        cout_o = (a_i & bx_o) | (cin_i & (a_i ^ bx_o));
    end

    // Purpose: output selector choosing the function result for this bit.
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_NOTA: res_o = ~a_i;
            OP_SLT:  res_o = less_i;
            default: res_o = sum_o;
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Module: alu_flag_unit
// Works out carry, overflow and the set-on-less-than bit from the top slice.
// It assumes the adder inputs seen here are A and the B value after the
// invert selector.
module alu_flag_unit (
    input  logic a_msb_i,
    input  logic bx_msb_i,
    input  logic sum_msb_i,
    input  logic carry_i,
    input  logic arith_i,
    input  logic sgn_ovf_i,
    input  logic uadd_i,
    input  logic usub_i,
    output logic carry_o,
    output logic ovf_o,
    output logic slt_o
);

    logic sgn_ovf;

    // Purpose: a sign mismatch between like-signed adder inputs and the sum.
    always_comb begin
        sgn_ovf = (a_msb_i == bx_msb_i) && (sum_msb_i != a_msb_i);
        slt_o   = sum_msb_i ^ sgn_ovf;
    end

    // Purpose: choose the overflow rule by operation class.
    always_comb begin
        carry_o = arith_i & carry_i;
        if (sgn_ovf_i)   ovf_o = sgn_ovf;
        else if (uadd_i) ovf_o = carry_i;
        else if (usub_i) ovf_o = ~carry_i;
        else             ovf_o = 1'b0;
    end

endmodule

// File: rtl/ripple_alu.sv
// Module: ripple_alu (top)
// A combinational ALU built as a ripple chain of WIDTH one-bit slices.
// It assumes WIDTH >= 2. The immediate assertions below compare the outputs
// against wide-integer arithmetic.
module ripple_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] y_o,
    output logic             carry_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    alu_op_e    op;
    logic       inv_b, arith, sgn_ovf_en, uadd, usub;
    logic       slt;
    logic [MSB:0] sum_w, bx_w;

    // Purpose: view the raw code as the typed operation.
    always_comb op = alu_op_e'(op_i);

    alu_op_decode u_dec (
        .op_i      (op),
        .inv_b_o   (inv_b),
        .arith_o   (arith),
        .sgn_ovf_o (sgn_ovf_en),
        .uadd_o    (uadd),
        .usub_o    (usub)
    );

    // Each slice keeps its own carry signals so the chain stays acyclic.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic cin_w, cout_w, less_w;
        if (i == 0) begin : g_lsb
            assign cin_w  = inv_b;
            assign less_w = slt;
        end else begin : g_up
            assign cin_w  = g_bit[i-1].cout_w;
            assign less_w = 1'b0;
        end
        alu_bit_cell u_cell (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .cin_i  (cin_w),
            .inv_i  (inv_b),
            .less_i (less_w),
            .op_i   (op),
            .res_o  (y_o[i]),
            .sum_o  (sum_w[i]),
            .cout_o (cout_w),
            .bx_o   (bx_w[i])
        );
    end

    alu_flag_unit u_flag (
        .a_msb_i   (a_i[MSB]),
        .bx_msb_i  (bx_w[MSB]),
        .sum_msb_i (sum_w[MSB]),
        .carry_i   (g_bit[MSB].cout_w),
        .arith_i   (arith),
        .sgn_ovf_i (sgn_ovf_en),
        .uadd_i    (uadd),
        .usub_i    (usub),
        .carry_o   (carry_o),
        .ovf_o     (ovf_o),
        .slt_o     (slt)
    );

    // Purpose: output checks against wide arithmetic, kept beside the flags.
    always_comb begin
        logic [WIDTH:0]        u_add;
        logic signed [WIDTH:0] s_add, s_sub;
        u_add = {1'b0, a_i} + {1'b0, b_i};
        s_add = $signed({a_i[MSB], a_i}) + $signed({b_i[MSB], b_i});
        s_sub = $signed({a_i[MSB], a_i}) - $signed({b_i[MSB], b_i});
        if (!$isunknown({op_i, a_i, b_i})) begin
            if (op_i == 3'b000 || op_i == 3'b001 || op_i == 3'b101)
                assert_logic_no_flags_R3: assert (!carry_o && !ovf_o);
            if (op_i == 3'b010) begin
                assert_sadd_result_R4: assert (y_o == u_add[MSB:0] && carry_o == u_add[WIDTH]);
                assert_sadd_ovf_R6: assert (ovf_o == (s_add[WIDTH] != s_add[MSB]));
            end
            if (op_i == 3'b011)
                assert_ssub_ovf_R6: assert (ovf_o == (s_sub[WIDTH] != s_sub[MSB]));
            if (op_i == 3'b110)
                assert_uadd_ovf_R7: assert (ovf_o == u_add[WIDTH]);
            if (op_i == 3'b111)
                assert_usub_borrow_R8: assert (ovf_o == (a_i < b_i));
            if (op_i == 3'b100)
                assert_slt_result_R9: assert (y_o == WIDTH'($signed(a_i) < $signed(b_i)) && !ovf_o && !carry_o);
        end
    end

endmodule

// File: tb/sim_ripple_alu.sv
`timescale 1ns/1ps
// Directed bench: an 8-bit instance with targeted patterns and a 4-bit
// instance swept over every operand pair and code.
module sim_ripple_alu;

    localparam int W0 = 8;
    localparam int W1 = 4;

    logic clk = 1'b0;
    logic rst_n;
    always #2 clk = ~clk;   // 250 MHz

    logic [W0-1:0] a0, b0, y0;
    logic [2:0]    op0;
    logic          c0, v0;
    logic [W1-1:0] a1, b1, y1;
    logic [2:0]    op1;
    logic          c1, v1;

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    ripple_alu #(.WIDTH(W0)) u0 (.a_i(a0), .b_i(b0), .op_i(op0), .y_o(y0), .carry_o(c0), .ovf_o(v0));
    ripple_alu #(.WIDTH(W1)) u1 (.a_i(a1), .b_i(b1), .op_i(op1), .y_o(y1), .carry_o(c1), .ovf_o(v1));

    // Reference model built from the requirements with 64-bit integers.
    function automatic void ref_model(input int w, input logic [2:0] op, input longint a, input longint b,
                                      output longint r, output bit c, output bit v);
        longint m, sa, sb, s, sg, hi, lo;
        m  = (longint'(1) << w) - 1;
        hi = (longint'(1) << (w - 1)) - 1;
        lo = -(longint'(1) << (w - 1));
        sa = (a > hi) ? a - (longint'(1) << w) : a;
        sb = (b > hi) ? b - (longint'(1) << w) : b;
        r = 0; c = 1'b0; v = 1'b0;
        case (op)
            3'b000: r = a & b;
            3'b001: r = a | b;
            3'b101: r = (~a) & m;
            3'b010, 3'b110: begin
                s = a + b; r = s & m; c = ((s >> w) & 1) != 0;
                sg = sa + sb;
                v = (op == 3'b010) ? (sg > hi || sg < lo) : c;
            end
            3'b011, 3'b111: begin
                s = a + ((~b) & m) + 1; r = s & m; c = ((s >> w) & 1) != 0;
                sg = sa - sb;
                v = (op == 3'b011) ? (sg > hi || sg < lo) : (a < b);
            end
            default: r = (sa < sb) ? 1 : 0;
        endcase
    endfunction

    // Pick the requirement tag that a mismatch belongs to.
    function automatic string tag_of(input logic [2:0] op, input bit flag_bad, input bit v_bad);
        if (flag_bad && (op == 3'b000 || op == 3'b001 || op == 3'b101)) return "R3";
        if (v_bad && (op == 3'b010 || op == 3'b011)) return "R6";
        case (op)
            3'b000, 3'b001: return "R1";
            3'b101:         return "R2";
            3'b010:         return "R4";
            3'b011:         return "R5";
            3'b110:         return "R7";
            3'b111:         return "R8";
            default:        return "R9";
        endcase
    endfunction

    // Compare one set of outputs with the reference model.
    task automatic judge(input string inst, input int w, input logic [2:0] op, input longint a, input longint b,
                         input longint y, input bit c, input bit v);
        longint er; bit ec, ev;
        ref_model(w, op, a, b, er, ec, ev);
        checks++;
        if (y != er || c != ec || v != ev) begin
            failures++;
            $display("FAIL %s %s op=%b a=%0h b=%0h y=%0h exp=%0h carry=%0b exp=%0b ovf=%0b exp=%0b",
                     tag_of(op, (c != ec) || (v != ev), v != ev), inst, op, a, b, y, er, c, ec, v, ev);
        end
    endtask

    // Drive the 8-bit instance and check it half a cycle later.
    task automatic apply8(input logic [2:0] op, input logic [W0-1:0] a, input logic [W0-1:0] b);
        @(posedge clk);
        op0 = op; a0 = a; b0 = b;
        @(negedge clk);
        judge("u0", W0, op, longint'(a), longint'(b), longint'(y0), c0, v0);
    endtask

    task automatic t_reset_state;   // R1: zero inputs under AND give zero outputs
        @(negedge clk);
        judge("u0", W0, op0, longint'(a0), longint'(b0), longint'(y0), c0, v0);
    endtask

    task automatic t_and_or;        // R1 and R3
        apply8(3'b000, 8'hF0, 8'h3C);
        apply8(3'b000, 8'hFF, 8'hA5);
        apply8(3'b001, 8'h0F, 8'h30);
        apply8(3'b001, 8'h00, 8'h00);
    endtask

    task automatic t_not_a;         // R2: B has no effect on the outputs
        apply8(3'b101, 8'h5A, 8'h00);
        apply8(3'b101, 8'h5A, 8'hFF);
        apply8(3'b101, 8'h00, 8'h81);
    endtask

    task automatic t_signed_add;    // R4 and R6
        apply8(3'b010, 8'h05, 8'h03);
        apply8(3'b010, 8'h7F, 8'h01);   // positive overflow
        apply8(3'b010, 8'h80, 8'h80);   // most negative plus itself
        apply8(3'b010, 8'h7F, 8'h80);   // mixed signs never overflow
        apply8(3'b010, 8'hFF, 8'h01);   // carry without overflow
    endtask

    task automatic t_signed_sub;    // R5 and R6
        apply8(3'b011, 8'h09, 8'h04);
        apply8(3'b011, 8'h7F, 8'h80);   // overflow through the inverted B sign
        apply8(3'b011, 8'h80, 8'h01);
        apply8(3'b011, 8'h00, 8'h80);
        apply8(3'b011, 8'h33, 8'h33);
    endtask

    task automatic t_unsigned;      // R7 and R8
        apply8(3'b110, 8'hFF, 8'h01);   // maximum plus one
        apply8(3'b110, 8'h80, 8'h7F);
        apply8(3'b111, 8'h01, 8'h02);   // borrow
        apply8(3'b111, 8'h02, 8'h02);
        apply8(3'b111, 8'h00, 8'hFF);
    endtask

    task automatic t_slt;           // R9
        apply8(3'b100, 8'h80, 8'h7F);   // internal difference overflows
        apply8(3'b100, 8'h7F, 8'h80);
        apply8(3'b100, 8'hFF, 8'h00);
        apply8(3'b100, 8'h10, 8'h10);
        apply8(3'b100, 8'h02, 8'h05);
    endtask

    task automatic t_mixed_patterns;  // R10: spread of values on every code
        logic [W0-1:0] x = 8'h1D;
        for (int k = 0; k < 64; k++) begin
            logic [W0-1:0] y;
            x = x * 8'd73 + 8'd41;
            y = x ^ 8'hC3;
            apply8(3'(k), x, y);
        end
    endtask

    task automatic t_narrow_sweep;  // R10: exhaustive on the 4-bit instance
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    @(posedge clk);
                    op1 = 3'(op); a1 = 4'(a); b1 = 4'(b);
                    @(negedge clk);
                    judge("u1", W1, 3'(op), longint'(a), longint'(b), longint'(y1), c1, v1);
                end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        op0 = 3'b000; a0 = '0; b0 = '0;
        op1 = 3'b000; a1 = '0; b1 = '0;
        repeat (3) @(posedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_and_or();
        t_not_a();
        t_signed_add();
        t_signed_sub();
        t_unsigned();
        t_slt();
        t_mixed_patterns();
        t_narrow_sweep();
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule